// File: doc/BRIEF.md
# Two-Bank Level Interrupt Controller with Fast-Interrupt Steering

This block gathers sixty-four peripheral interrupt lines, split into two banks of thirty-two, and eight core-local lines. It drives one normal interrupt output and one fast-interrupt output. Every line is level-sensitive. A line counts as pending only while its input is high and its enable bit is set. Nothing is latched, so a pending bit falls as soon as its input falls.

Software reaches the block through a single-cycle 32-bit register port: an address, a write strobe, write data and combinational read data. Enables change only through write-one-to-set and write-one-to-clear registers, so no read-modify-write sequence is needed. A summary register gathers four things in one word: the masked core-local lines, one "anything pending" flag per peripheral bank, and copies of eleven fixed peripheral lines. An interrupt handler can often decide what to service from this word alone.

One line, peripheral or core-local, can be steered to the fast-interrupt output. That path uses the raw input level and ignores the line's normal enable. Both outputs are registered.

Top module: `irq_router`

## Requirements
- R1: After reset all enables are zero, the fast-interrupt select and enable are zero, and both outputs are low.
- R2: Offset 0x04 reads (level AND enable) of peripheral lines 0-31 and offset 0x08 reads the same for lines 32-63. Each bit follows its input level with no latching.
- R3: Writing ones to 0x10 (lines 0-31), 0x14 (lines 32-63) or 0x18 (core-local bits 7:0) sets those enables; zero bits change nothing. Reading any of these offsets returns the current enables.
- R4: Writing ones to 0x1C (lines 0-31), 0x20 (lines 32-63) or 0x24 (core-local) clears those enables; zero bits change nothing. Reading any of these offsets returns the bitwise inverse of the current enables, with ones in bits 31:8 at 0x24.
- R5: Offset 0x00 reads a summary word, built as follows. Bits 7:0 are the masked core-local lines. Bit 8 is set when any of lines 0-31 is pending, and bit 9 when any of lines 32-63 is pending. Bits 10 to 19 copy the pending state of lines 7, 9, 10, 18, 19, 53, 54, 55, 56 and 57, in that order, and bit 20 copies line 62. Bits 31:21 read zero.
- R6: `irq_o` is high when any peripheral or core-local line is pending. It updates one clock after the input or the enable changes.
- R7: Offset 0x0C holds the fast-interrupt control: bits 6:0 are the source select and bit 7 is the enable. It reads back with bits 31:8 zero.
- R8: With the fast-interrupt enable set, `fiq_o` equals the raw level of the selected line, one clock later, whatever that line's enable is. Selects 0-63 pick peripheral lines, and 64-71 pick core-local line (select-64). Selects 72-127 give low, and a cleared enable gives low.
- R9: Unknown offsets read zero and ignore writes. Writes to 0x00, 0x04 and 0x08 change no state.
- R10: Only bits 7:0 of a core-local set or clear write take effect. Bits 31:8 of the core-local enable read at 0x18 are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Register byte offset |
| we_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data |
| periph_i | input | 64 | Peripheral line levels |
| local_i | input | 8 | Core-local line levels |
| irq_o | output | 1 | Registered normal interrupt |
| fiq_o | output | 1 | Registered fast interrupt |

## Verification
The bench builds the block with the default ADDR_W of 8. That puts every decoded offset in reach, along with unmapped offsets such as 0x28 and 0x30 inside the same window, so the ignored-write and read-zero paths run against real neighbours. The bank split and the shortcut list are fixed by the package. Because of that, the bench aims its stimulus at bank-boundary lines and shortcut members, including line 62 and the lines next to it.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int WORD_W   = 32;
  localparam int N_BANK   = 2;
  localparam int N_PERIPH = N_BANK * WORD_W;
  localparam int N_LOCAL  = 8;
  localparam int SEL_W    = 7;
  localparam int N_SHORT  = 11;
  localparam int SUM_BANK_LSB  = N_LOCAL;
  localparam int SUM_SHORT_LSB = SUM_BANK_LSB + N_BANK;

  localparam int OFF_SUMMARY = 'h00;
  localparam int OFF_PEND0   = 'h04;
  localparam int OFF_FIQCTL  = 'h0C;
  localparam int OFF_SET0    = 'h10;
  localparam int OFF_LSET    = 'h18;
  localparam int OFF_CLR0    = 'h1C;
  localparam int OFF_LCLR    = 'h24;

  // peripheral line copied into summary bit SUM_SHORT_LSB + k
  function automatic int short_src(input int k);
    case (k)
      0: return 7;
      1: return 9;
      2: return 10;
      3: return 18;
      4: return 19;
      5: return 53;
      6: return 54;
      7: return 55;
      8: return 56;
      9: return 57;
      default: return 62;
    endcase
  endfunction
endpackage

// File: rtl/irq_enable_bank.sv
module irq_enable_bank #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] bits_i,
  output logic [W-1:0] en_o
);
  logic [W-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    en_q <= '0;
    else if (set_i) en_q <= en_q | bits_i;
    else if (clr_i) en_q <= en_q & ~bits_i;
  end

  assign en_o = en_q;
endmodule

// File: rtl/irq_fiq_sel.sv
module irq_fiq_sel
  import irq_router_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [7:0]          ctl_i,
  input  logic [N_PERIPH-1:0] periph_i,
  input  logic [N_LOCAL-1:0]  local_i,
  output logic [7:0]          ctl_o,
  output logic                fiq_o
);
  localparam int PW = $clog2(N_PERIPH);
  localparam int LW = $clog2(N_LOCAL);

  logic [SEL_W-1:0] sel_q;
  logic             en_q;
  logic [SEL_W-1:0] loc_off;
  logic             hit;
  logic             fiq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      en_q  <= 1'b0;
    end else if (we_i) begin
      sel_q <= ctl_i[SEL_W-1:0];
      en_q  <= ctl_i[7];
    end
  end

  assign loc_off = sel_q - SEL_W'(N_PERIPH);

  always_comb begin
    if (int'(sel_q) < N_PERIPH)                hit = periph_i[sel_q[PW-1:0]];
    else if (int'(sel_q) < N_PERIPH + N_LOCAL) hit = local_i[loc_off[LW-1:0]];
    else                                       hit = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fiq_q <= 1'b0;
    else         fiq_q <= en_q & hit;
  end

  assign ctl_o = {en_q, sel_q};
  assign fiq_o = fiq_q;
endmodule

// File: rtl/irq_readback.sv
module irq_readback
  import irq_router_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [N_PERIPH-1:0] pend_p_i,
  input  logic [N_PERIPH-1:0] en_p_i,
  input  logic [N_LOCAL-1:0]  pend_l_i,
  input  logic [N_LOCAL-1:0]  en_l_i,
  input  logic [7:0]          ctl_i,
  output logic [WORD_W-1:0]   rdata_o
);
  logic [WORD_W-1:0] summary;

  always_comb begin
    summary = '0;
    summary[N_LOCAL-1:0] = pend_l_i;
    for (int b = 0; b < N_BANK; b++)
      summary[SUM_BANK_LSB+b] = |pend_p_i[b*WORD_W +: WORD_W];
    for (int k = 0; k < N_SHORT; k++)
      summary[SUM_SHORT_LSB+k] = pend_p_i[short_src(k)];
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(OFF_SUMMARY)) rdata_o = summary;
    if (addr_i == ADDR_W'(OFF_FIQCTL))  rdata_o = {24'h0, ctl_i};
    if (addr_i == ADDR_W'(OFF_LSET))    rdata_o = {{(WORD_W-N_LOCAL){1'b0}}, en_l_i};
    if (addr_i == ADDR_W'(OFF_LCLR))    rdata_o = ~{{(WORD_W-N_LOCAL){1'b0}}, en_l_i};
    for (int b = 0; b < N_BANK; b++) begin
      if (addr_i == ADDR_W'(OFF_PEND0 + 4*b)) rdata_o = pend_p_i[b*WORD_W +: WORD_W];
      if (addr_i == ADDR_W'(OFF_SET0 + 4*b))  rdata_o = en_p_i[b*WORD_W +: WORD_W];
      if (addr_i == ADDR_W'(OFF_CLR0 + 4*b))  rdata_o = ~en_p_i[b*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                we_i,
  input  logic [WORD_W-1:0]   wdata_i,
  output logic [WORD_W-1:0]   rdata_o,
  input  logic [N_PERIPH-1:0] periph_i,
  input  logic [N_LOCAL-1:0]  local_i,
  output logic                irq_o,
  output logic                fiq_o
);
  logic [N_PERIPH-1:0] en_periph;
  logic [N_LOCAL-1:0]  en_local;
  logic [N_PERIPH-1:0] pend_periph;
  logic [N_LOCAL-1:0]  pend_local;
  logic [7:0]          fiq_ctl;
  logic                irq_q;

  for (genvar b = 0; b < N_BANK; b++) begin : g_bank
    irq_enable_bank #(.W(WORD_W)) u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (we_i && addr_i == ADDR_W'(OFF_SET0 + 4*b)),
      .clr_i  (we_i && addr_i == ADDR_W'(OFF_CLR0 + 4*b)),
      .bits_i (wdata_i),
      .en_o   (en_periph[b*WORD_W +: WORD_W])
    );
  end

  irq_enable_bank #(.W(N_LOCAL)) u_local (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (we_i && addr_i == ADDR_W'(OFF_LSET)),
    .clr_i  (we_i && addr_i == ADDR_W'(OFF_LCLR)),
    .bits_i (wdata_i[N_LOCAL-1:0]),
    .en_o   (en_local)
  );

  irq_fiq_sel u_fiq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (we_i && addr_i == ADDR_W'(OFF_FIQCTL)),
    .ctl_i    (wdata_i[7:0]),
    .periph_i (periph_i),
    .local_i  (local_i),
    .ctl_o    (fiq_ctl),
    .fiq_o    (fiq_o)
  );

  assign pend_periph = periph_i & en_periph;
  assign pend_local  = local_i & en_local;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= (|pend_periph) | (|pend_local);
  end
  assign irq_o = irq_q;

  irq_readback #(.ADDR_W(ADDR_W)) u_rd (
    .addr_i   (addr_i),
    .pend_p_i (pend_periph),
    .en_p_i   (en_periph),
    .pend_l_i (pend_local),
    .en_l_i   (en_local),
    .ctl_i    (fiq_ctl),
    .rdata_o  (rdata_o)
  );
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
  import irq_router_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [ADDR_W-1:0]   addr_i,
  input logic                we_i,
  input logic [WORD_W-1:0]   wdata_i,
  input logic [WORD_W-1:0]   rdata_o,
  input logic [N_PERIPH-1:0] periph_i,
  input logic [N_LOCAL-1:0]  local_i,
  input logic                irq_o,
  input logic                fiq_o,
  input logic [N_PERIPH-1:0] en_periph,
  input logic [N_LOCAL-1:0]  en_local,
  input logic [7:0]          fiq_ctl
);
  assert_irq_lag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == $past((|(periph_i & en_periph)) | (|(local_i & en_local))));

  assert_pend_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(OFF_PEND0)) |-> rdata_o == (periph_i[31:0] & en_periph[31:0]));

  assert_set_takes_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(OFF_SET0)) |=>
      ((en_periph[31:0] & $past(wdata_i)) == $past(wdata_i)));

  assert_clr_takes_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(OFF_CLR0)) |=> ((en_periph[31:0] & $past(wdata_i)) == '0));

  assert_fiq_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fiq_ctl[7] |=> !fiq_o);

  assert_unmapped_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'('h28)) |-> rdata_o == '0);

  assert_local_upper_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(OFF_LSET)) |-> rdata_o[31:8] == '0);
endmodule

bind irq_router irq_router_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .we_i      (we_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .periph_i  (periph_i),
  .local_i   (local_i),
  .irq_o     (irq_o),
  .fiq_o     (fiq_o),
  .en_periph (en_periph),
  .en_local  (en_local),
  .fiq_ctl   (fiq_ctl)
);

// File: tb/tb_irq_router.sv
`timescale 1ns/1ps
module tb_irq_router;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [63:0] periph_i = '0;
  logic [7:0]  local_i = '0;
  logic        irq_o, fiq_o;

  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  irq_router dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .periph_i(periph_i),
    .local_i(local_i), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic clear_all();
    wr(8'h1C, 32'hFFFF_FFFF);
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h24, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h10, d); chk("R1 en0", d, 32'h0);
    rd(8'h14, d); chk("R1 en1", d, 32'h0);
    rd(8'h18, d); chk("R1 enl", d, 32'h0);
    rd(8'h0C, d); chk("R1 fiqctl", d, 32'h0);
    rd(8'h24, d); chk("R4 inv local", d, 32'hFFFF_FFFF);
    chk("R1 irq", {31'h0, irq_o}, 32'h0);
    chk("R1 fiq", {31'h0, fiq_o}, 32'h0);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    wr(8'h10, 32'h0000_00F0);
    wr(8'h10, 32'h0000_0003);
    rd(8'h10, d); chk("R3 or-set", d, 32'h0000_00F3);
    wr(8'h14, 32'h8000_0001);
    rd(8'h14, d); chk("R3 set bank1", d, 32'h8000_0001);
    wr(8'h1C, 32'h0000_0030);
    rd(8'h10, d); chk("R4 clear", d, 32'h0000_00C3);
    rd(8'h1C, d); chk("R4 inv read", d, ~32'h0000_00C3);
    rd(8'h20, d); chk("R4 inv bank1", d, ~32'h8000_0001);
    wr(8'h18, 32'hFFFF_F1FF);
    rd(8'h18, d); chk("R10 local width", d, 32'h0000_00FF);
    wr(8'h24, 32'hFFFF_FF01);
    rd(8'h24, d); chk("R4 local clear inv", d, 32'hFFFF_FF01);
    rd(8'h18, d); chk("R10 local after clr", d, 32'h0000_00FE);
  endtask

  task automatic t_pending();
    logic [31:0] d;
    clear_all();
    wr(8'h10, 32'h0000_FF00);
    wr(8'h14, 32'h0F00_0000);
    periph_i = 64'h0300_0000_0000_0F0F;
    rd(8'h04, d); chk("R2 pend0", d, 32'h0000_0F00);
    rd(8'h08, d); chk("R2 pend1", d, 32'h0300_0000);
    periph_i = '0;
    rd(8'h04, d); chk("R2 no latch", d, 32'h0);
  endtask

  task automatic t_summary();
    logic [31:0] d;
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h18, 32'h0000_00FF);
    periph_i = '0; periph_i[9] = 1'b1; periph_i[62] = 1'b1;
    local_i = 8'h05;
    rd(8'h00, d); chk("R5 summary a", d, 32'h0010_0B05);
    periph_i = '0; periph_i[7] = 1'b1; periph_i[53] = 1'b1;
    local_i = '0;
    rd(8'h00, d); chk("R5 summary b", d, 32'h0000_8700);
    wr(8'h20, 32'h0200_0000);
    periph_i = '0; periph_i[57] = 1'b1;
    rd(8'h00, d); chk("R5 masked shortcut", d, 32'h0);
    periph_i = '0;
  endtask

  task automatic t_irq();
    clear_all();
    periph_i = 64'hFFFF_FFFF_FFFF_FFFF; local_i = 8'hFF;
    @(negedge clk_i);
    chk("R6 masked irq", {31'h0, irq_o}, 32'h0);
    periph_i = '0; local_i = 8'h08;
    wr(8'h18, 32'h0000_0008);
    chk("R6 one clock lag", {31'h0, irq_o}, 32'h0);
    @(negedge clk_i);
    chk("R6 irq high", {31'h0, irq_o}, 32'h1);
    local_i = '0;
    #1 chk("R6 before edge", {31'h0, irq_o}, 32'h1);
    @(negedge clk_i);
    chk("R6 irq falls", {31'h0, irq_o}, 32'h0);
  endtask

  task automatic t_fiq();
    logic [31:0] d;
    clear_all();
    periph_i = 64'h20;
    wr(8'h0C, 32'h0000_0085);
    @(negedge clk_i);
    chk("R8 fiq raw", {31'h0, fiq_o}, 32'h1);
    periph_i = '0;
    @(negedge clk_i);
    chk("R8 fiq follows", {31'h0, fiq_o}, 32'h0);
    local_i = 8'h04;
    wr(8'h0C, 32'h0000_00C2);
    @(negedge clk_i);
    chk("R8 fiq local", {31'h0, fiq_o}, 32'h1);
    periph_i = '1; local_i = '1;
    wr(8'h0C, 32'h0000_00C8);
    @(negedge clk_i);
    chk("R8 select 72 none", {31'h0, fiq_o}, 32'h0);
    wr(8'h0C, 32'h0000_0005);
    @(negedge clk_i);
    chk("R8 fiq disabled", {31'h0, fiq_o}, 32'h0);
    wr(8'h0C, 32'hFFFF_FF85);
    rd(8'h0C, d); chk("R7 ctl readback", d, 32'h0000_0085);
    periph_i = '0; local_i = '0;
    wr(8'h0C, 32'h0);
  endtask

  task automatic t_unknown();
    logic [31:0] d;
    clear_all();
    wr(8'h10, 32'h0000_1234);
    wr(8'h28, 32'hFFFF_FFFF);
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h28, d); chk("R9 unmapped read", d, 32'h0);
    rd(8'h30, d); chk("R9 unmapped read 30", d, 32'h0);
    rd(8'h10, d); chk("R9 en0 kept", d, 32'h0000_1234);
    rd(8'h14, d); chk("R9 en1 kept", d, 32'h0);
    rd(8'h18, d); chk("R9 local kept", d, 32'h0);
    rd(8'h0C, d); chk("R9 ctl kept", d, 32'h0);
    rd(8'h04, d); chk("R9 pend read-only", d, 32'h0);
  endtask

  initial begin
    #4_000_000;
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_enable();
    t_pending();
    t_summary();
    t_irq();
    t_fiq();
    t_unknown();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule